// File: doc/BRIEF.md
# One-Bit Bitstream PAM Lowpass Filter

This block smooths an oversampled one-bit bitstream into a multi-bit pulse-amplitude word at the same rate as the bits. It keeps the most recent bits in a short delay line. Each bit is read as +1 for a one and -1 for a zero, and the block adds up those signs, each scaled by its own signed tap coefficient. No multiplier is needed. Each tap adds either its weight or its negation. A tap with a negative coefficient uses the inverted bit and the magnitude of the weight.

The coefficient set is a parameter. The intended kernel puts its largest weight on the newest tap, which keeps the group delay short. The output word is as wide as the sum of the absolute coefficient values requires, so the result is never rounded or clipped. One output word comes out for every accepted input bit, one clock later, and nothing is decimated.

Top module: `bitstream_pam_filter`

## Requirements
- R1: On each cycle with `in_valid` high, the delay line shifts by one tap. `in_bit` enters tap 0, which holds the newest bit, and tap k takes the old contents of tap k-1.
- R2: On a cycle with `in_valid` low, neither the delay line nor `out_data` changes.
- R3: A tap bit of 1 counts as +1 and a bit of 0 as -1. Tap k is scaled by coefficient k, which sits in bits [k*COEF_W +: COEF_W] of `COEF_VEC` as a two's-complement value. The output is the signed sum over all taps.
- R4: A tap with a negative coefficient contributes its magnitude when its bit is 0 and minus its magnitude when its bit is 1. For the default set (40, 32, 22, 12, 4, -3, -5, -2 for taps 0 to 7), all-ones history gives +100 and all-zeros history gives -100.
- R5: The sum is kept at full precision in a signed word of width clog2(S+1)+1, where S is the sum of absolute coefficients (S = 120 and width 8 by default). `out_data` always lies in [-S, S], and its parity equals the parity of S.
- R6: `out_valid` rises exactly one clock after a cycle with `in_valid` high. On that cycle `out_data` already includes the bit just accepted.
- R7: A synchronous active-high `rst` loads tap k with 1 for even k and 0 for odd k, and clears `out_data` and `out_valid` to 0. With the defaults, a first bit of 0 after reset yields -22.
- R8: Back-to-back valid bits produce one output word per clock, with no gaps and no words dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit strobe |
| in_bit | input | 1 | Bitstream sample |
| out_valid | output | 1 | Output word strobe, one cycle after `in_valid` |
| out_data | output | OUT_W | Signed full-precision filtered word |

## Verification
Some properties are checked by assertions on every cycle. These are the shift and hold behaviour of the delay line, the reload of the alternating pattern after reset, the one-cycle valid timing, the freezing of the output on idle cycles, and the range and parity limits of the output word. The exact value of each word cannot be shown by these per-cycle properties. That includes the sign convention for bits, the inverted-bit handling of negative weights, and the full-scale extremes. Those are shown only by the bench's scenarios, in which a separate model of the tap history predicts every word. The scenarios are steady ones and zeros, extreme patterns, a walking impulse, the first word after reset, and a long gapped pseudo-random stream.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  localparam int MAX_COEF_BITS = 1024;

  // sum of |coefficient| over the packed coefficient vector
  function automatic int abs_total(input logic [MAX_COEF_BITS-1:0] vec,
                                   input int n_taps, input int cw);
    int total;
    int w;
    total = 0;
    for (int k = 0; k < n_taps; k++) begin
      w = 0;
      for (int b = 0; b < cw; b++) begin
        if (vec[k*cw+b]) w = w + (1 << b);
      end
      if (vec[k*cw+cw-1]) w = w - (1 << cw);
      total = total + ((w < 0) ? -w : w);
    end
    return total;
  endfunction

  // word width able to hold +/- total without loss
  function automatic int word_width(input int total);
    return $clog2(total + 1) + 1;
  endfunction

  // reset contents of tap k: ones on even taps
  function automatic logic reset_tap(input int k);
    return (k % 2) == 0;
  endfunction

  // signed contribution of one tap after the negative-weight inversion
  function automatic int tap_term(input logic eff_bit, input int magnitude);
    return eff_bit ? magnitude : -magnitude;
  endfunction

endpackage

// File: rtl/bsf_delay_line.sv
module bsf_delay_line #(
  parameter int NUM_TAPS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic [NUM_TAPS-1:0] taps_shifted
);
  import bsf_pkg::*;

  logic [NUM_TAPS-1:0] taps_q;
  logic [NUM_TAPS-1:0] rst_pattern;

  generate
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_pat
      assign rst_pattern[k] = reset_tap(k);
    end
    if (NUM_TAPS > 1) begin : g_multi
      assign taps_shifted = {taps_q[NUM_TAPS-2:0], bit_in};
    end else begin : g_single
      assign taps_shifted = bit_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      taps_q <= rst_pattern;
    end else if (shift_en) begin
      taps_q <= taps_shifted;
    end
  end

  AST_SHIFT_NEWEST: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> taps_q[0] == $past(bit_in)); // R1
  generate
    if (NUM_TAPS > 1) begin : g_shift_chk
      AST_SHIFT_OLDER: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> taps_q[NUM_TAPS-1:1] == $past(taps_q[NUM_TAPS-2:0])); // R1
    end
  endgenerate
  AST_HOLD_TAPS: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(taps_q)); // R2
  AST_RESET_PATTERN: assert property (@(posedge clk)
    $past(rst) |-> taps_q == rst_pattern); // R7

endmodule

// File: rtl/bsf_tap_weight.sv
module bsf_tap_weight #(
  parameter int                         NUM_TAPS = 8,
  parameter int                         COEF_W   = 8,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEF_VEC = '0,
  parameter int                         OUT_W    = 8
) (
  input  logic [NUM_TAPS-1:0]       taps,
  output logic [NUM_TAPS-1:0]       tap_eff,
  output logic [NUM_TAPS*OUT_W-1:0] terms
);
  import bsf_pkg::*;

  generate
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
      localparam logic signed [COEF_W-1:0] W_K = COEF_VEC[k*COEF_W +: COEF_W];
      localparam int  W_I  = int'(W_K);
      localparam bit  NEG  = (W_I < 0);
      localparam int  MAG  = NEG ? -W_I : W_I;
      localparam logic signed [OUT_W-1:0] POS_V = OUT_W'(tap_term(1'b1, MAG));
      localparam logic signed [OUT_W-1:0] NEG_V = OUT_W'(tap_term(1'b0, MAG));

      // inverted bit for a negative weight, magnitude kept positive
      assign tap_eff[k] = taps[k] ^ NEG;
      assign terms[k*OUT_W +: OUT_W] = tap_eff[k] ? POS_V : NEG_V;
    end
  endgenerate

endmodule

// File: rtl/bsf_adder_tree.sv
module bsf_adder_tree #(
  parameter int NUM_TERMS = 8,
  parameter int WIDTH     = 8
) (
  input  logic [NUM_TERMS*WIDTH-1:0] terms,
  output logic signed [WIDTH-1:0]    total
);
  localparam int LEVELS = (NUM_TERMS > 1) ? $clog2(NUM_TERMS) : 1;
  localparam int PAD    = 1 << LEVELS;

  logic signed [WIDTH-1:0] node [LEVELS+1][PAD];

  generate
    for (genvar i = 0; i < PAD; i++) begin : g_leaf
      if (i < NUM_TERMS) begin : g_used
        assign node[0][i] = terms[i*WIDTH +: WIDTH];
      end else begin : g_pad
        assign node[0][i] = '0;
      end
    end
    for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
      for (genvar i = 0; i < PAD; i++) begin : g_node
        if (i < (PAD >> l)) begin : g_add
          assign node[l][i] = node[l-1][2*i] + node[l-1][2*i+1];
        end else begin : g_idle
          assign node[l][i] = '0;
        end
      end
    end
  endgenerate

  assign total = node[LEVELS][0];

endmodule

// File: rtl/bitstream_pam_filter.sv
module bitstream_pam_filter #(
  parameter int                         NUM_TAPS = 8,
  parameter int                         COEF_W   = 8,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEF_VEC = {8'shFE, 8'shFB, 8'shFD, 8'sd4,
                                                    8'sd12, 8'sd22, 8'sd32, 8'sd40},
  localparam int ABS_SUM = bsf_pkg::abs_total(bsf_pkg::MAX_COEF_BITS'(COEF_VEC),
                                              NUM_TAPS, COEF_W),
  localparam int OUT_W   = bsf_pkg::word_width(ABS_SUM)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_bit,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  logic [NUM_TAPS-1:0]       taps_shifted;
  logic [NUM_TAPS-1:0]       tap_eff;
  logic [NUM_TAPS*OUT_W-1:0] terms;
  logic signed [OUT_W-1:0]   sum_next;
  logic                      word_accept;

  assign word_accept = in_valid;

  bsf_delay_line #(.NUM_TAPS(NUM_TAPS)) u_delay (
    .clk          (clk),
    .rst          (rst),
    .shift_en     (word_accept),
    .bit_in       (in_bit),
    .taps_shifted (taps_shifted)
  );

  bsf_tap_weight #(
    .NUM_TAPS (NUM_TAPS),
    .COEF_W   (COEF_W),
    .COEF_VEC (COEF_VEC),
    .OUT_W    (OUT_W)
  ) u_weight (
    .taps    (taps_shifted),
    .tap_eff (tap_eff),
    .terms   (terms)
  );

  bsf_adder_tree #(.NUM_TERMS(NUM_TAPS), .WIDTH(OUT_W)) u_tree (
    .terms (terms),
    .total (sum_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= word_accept;
      if (word_accept) out_data <= sum_next;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R6
  AST_NO_SPURIOUS_WORD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data)); // R2
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(out_data) <= ABS_SUM) && (int'(out_data) >= -ABS_SUM)); // R5
  AST_OUT_PARITY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[0] == ABS_SUM[0])); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0)); // R7

endmodule

// File: tb/bitstream_pam_filter_tb_top.sv
module bitstream_pam_filter_tb_top;

  localparam int NT = 8;
  localparam int OW = 8;
  localparam int WEIGHTS [NT] = '{40, 32, 22, 12, 4, -3, -5, -2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int exp_q[$];
  int hist [NT];
  int last_out = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bitstream_pam_filter dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // model: +1/-1 history times signed weights
  function automatic int model_sum();
    int s = 0;
    for (int k = 0; k < NT; k++) s += (hist[k] != 0) ? WEIGHTS[k] : -WEIGHTS[k];
    return s;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NT; k++) hist[k] = (k % 2 == 0) ? 1 : 0;
  endtask

  // driver: present one cycle of input, push expected word when valid
  task automatic drive(input bit v, input bit b);
    @(negedge clk);
    in_valid = v;
    in_bit   = b;
    if (v) begin
      for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = b ? 1 : 0;
      exp_q.push_back(model_sum());
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      check(out_valid == in_valid, "R6 R8 out_valid timing", int'(out_valid), int'(in_valid));
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected word", int'(out_data), 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(out_data) == e, "R3 R6 word value", int'(out_data), e);
        end
        last_out = int'(out_data);
      end else begin
        check(int'(out_data) == last_out, "R2 idle hold", int'(out_data), last_out);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      check(1'b0, "watchdog expired", cycles, 0);
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
    check(int'(out_data) == 0, "R7 reset out_data", int'(out_data), 0);
    rst = 1'b0;
    idle(2);

    // first word after reset uses the alternating pattern
    drive(1'b1, 1'b0);
    idle(1);
    check(int'(out_data) == -22, "R7 first word after reset", int'(out_data), -22);
    idle(4);
    check(int'(out_data) == -22, "R2 hold after idle", int'(out_data), -22);

    // steady ones and zeros
    for (int i = 0; i < NT; i++) drive(1'b1, 1'b1);
    idle(1);
    check(int'(out_data) == 100, "R4 all ones", int'(out_data), 100);
    for (int i = 0; i < NT; i++) drive(1'b1, 1'b0);
    idle(1);
    check(int'(out_data) == -100, "R4 all zeros", int'(out_data), -100);

    // walking impulse
    drive(1'b1, 1'b1);
    idle(1);
    check(int'(out_data) == -20, "R1 impulse at tap 0", int'(out_data), -20);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0);
    idle(1);
    check(int'(out_data) == -76, "R1 impulse at tap 3", int'(out_data), -76);

    // full-scale extremes: negative taps inverted
    for (int i = 0; i < NT; i++) drive(1'b1, (i < 3) ? 1'b1 : 1'b0);
    idle(1);
    check(int'(out_data) == -120, "R4 R5 negative full scale", int'(out_data), -120);
    for (int i = 0; i < NT; i++) drive(1'b1, (i < 3) ? 1'b0 : 1'b1);
    idle(1);
    check(int'(out_data) == 120, "R4 R5 positive full scale", int'(out_data), 120);

    // alternating back-to-back
    for (int i = 0; i < 16; i++) drive(1'b1, i[0]);
    idle(2);

    // gapped pseudo-random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[3:2] != 2'b00, lfsr[0]);
    end
    idle(3);
    check(exp_q.size() == 0, "R8 all words delivered", exp_q.size(), 0);

    // reset mid-stream restores the pattern
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    last_out = 0;
    check(int'(out_data) == 0, "R7 reset clears word", int'(out_data), 0);
    drive(1'b1, 1'b0);
    idle(1);
    check(int'(out_data) == -22, "R7 pattern after second reset", int'(out_data), -22);
    idle(2);

    done = 1'b1;
    finish_run();
  end

endmodule